// File: doc/BRIEF.md
# External Interrupt Acceptance Unit

This block sits beside a small 32-bit processor core. It decides whether a pending external interrupt is taken, and in which cycle. Requests come from four kinds of source:

- an NMI pin that is edge-detected and latched;
- a 4-bit encoded priority level;
- a set of IRQ pins, each with its own programmable 4-bit priority;
- a set of port-interrupt pins, each with its own programmable 4-bit priority.

The unit looks at the status register (SR) that the core presents, in particular its block bit and its 4-bit mask field. It accepts a request only in a cycle in which the core marks an instruction boundary.

When a request is accepted, the unit registers the full exception-entry record and raises a single-cycle `take` pulse. The record holds:

- the return PC and the SR to save;
- the 12-bit event code of the winning source;
- the SR value the core must load;
- the handler address, which is the vector base plus a fixed offset of 0x600.

The core copies these values into its own registers. The unit never writes the accepted level into the SR mask field.

Top module: `irq_accept_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it, `take` is 0 and every record output reads 0.
- R2: A rising edge on `nmi_pin` latches an NMI request. That request ignores the mask field SR[7:4], wins over every other source and reports event code 0x1C0.
- R3: Any request is refused while the block bit SR[28] is 1. A latched NMI stays pending until it is taken. One edge yields exactly one NMI acceptance.
- R4: A level request `lvl_in` is accepted only when SR[28] is 0 and SR[7:4] is strictly below `lvl_in`. Its event code is 0x200 + `lvl_in`×0x20.
- R5: IRQ pin i is accepted when it is high, SR[28] is 0 and SR[7:4] is strictly below its priority `irq_prio[4i+3:4i]`. Its event code is 0x600 + i×0x20.
- R6: Port pin j is accepted under the same rule, using `port_prio[4j+3:4j]`. Its event code is 0x700 + j×0x20.
- R7: Among eligible sources the order is NMI, then level, then the IRQ group, then the port group. Inside a group the highest priority wins, and on a tie the lowest index wins.
- R8: No request is accepted in a cycle where `insn_boundary` is 0.
- R9: An acceptance decided in cycle N shows `take`=1 in cycle N+1. In that cycle, `saved_pc` and `saved_sr` equal the `pc_next` and `sr_in` of cycle N.
- R10: On `take`, `new_sr` equals the saved SR with bits 28 (block), 29 (bank) and 30 (mode) set to 1 and bits 7:4 unchanged.
- R11: On `take`, `target_pc` equals cycle N's `vbr` + 0x600.
- R12: `take` lasts one cycle, and no request is accepted in the cycle in which `take` is high.
- R13: A `lvl_in` of 0 never produces a request, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Non-maskable request, rising-edge sensitive |
| lvl_in | input | 4 | Encoded request level, 0 = none |
| irq_pin | input | N_IRQ | IRQ request pins |
| irq_prio | input | 4×N_IRQ | Per-IRQ priority, 4 bits each |
| port_pin | input | N_PORT | Port-interrupt request pins |
| port_prio | input | 4×N_PORT | Per-port priority, 4 bits each |
| sr_in | input | XLEN | Current status register |
| pc_next | input | XLEN | PC of the instruction after the boundary |
| vbr | input | XLEN | Vector base |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| take | output | 1 | One-cycle acceptance pulse |
| saved_pc | output | XLEN | PC to save |
| saved_sr | output | XLEN | SR to save |
| evt_code | output | 12 | Event code of the accepted source |
| new_sr | output | XLEN | SR the core loads on entry |
| target_pc | output | XLEN | Handler address |

## Verification
The assertions assume the following about the unit's inputs:

- `sr_in`, `pc_next` and `vbr` are stable across the clock edge at which they are sampled.
- `nmi_pin` is low during reset, so no edge appears at release.

The stimulus drives every input once per cycle, on the falling edge, and holds the NMI pin low through reset. It raises the block bit only through `sr_in`. Priorities are changed only between requests, never inside a cycle that could be accepted.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int PRIO_W   = 4;
  localparam int BIT_BL   = 28;
  localparam int BIT_RB   = 29;
  localparam int BIT_MD   = 30;
  localparam int IMASK_LO = 4;

  typedef enum logic [1:0] {
    SRC_NMI  = 2'd0,
    SRC_LVL  = 2'd1,
    SRC_IRQ  = 2'd2,
    SRC_PORT = 2'd3
  } src_e;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic clr,
  output logic pend
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pin_q <= pin;
      // a fresh edge wins over a clear in the same cycle
      pend  <= (pend & ~clr) | (pin & ~pin_q);
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N     = 4,
  parameter int PW    = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  input  logic [PW-1:0]   imask,
  input  logic            enable,
  output logic            hit,
  output logic [IDX_W-1:0] idx
);
  logic [PW-1:0] best;

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (enable && req[i] && (prio[i*PW +: PW] > imask) &&
          (!hit || (prio[i*PW +: PW] > best))) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        best = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int N_IRQ  = 6,
  parameter int N_PORT = 8,
  parameter int EVT_W  = 12,
  parameter logic [XLEN-1:0]  VEC_OFS       = 'h600,
  parameter logic [EVT_W-1:0] EVT_NMI       = 'h1C0,
  parameter logic [EVT_W-1:0] EVT_LVL_BASE  = 'h200,
  parameter logic [EVT_W-1:0] EVT_IRQ_BASE  = 'h600,
  parameter logic [EVT_W-1:0] EVT_PORT_BASE = 'h700,
  parameter logic [EVT_W-1:0] EVT_STEP      = 'h020
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  nmi_pin,
  input  logic [PRIO_W-1:0]     lvl_in,
  input  logic [N_IRQ-1:0]      irq_pin,
  input  logic [N_IRQ*PRIO_W-1:0]  irq_prio,
  input  logic [N_PORT-1:0]     port_pin,
  input  logic [N_PORT*PRIO_W-1:0] port_prio,
  input  logic [XLEN-1:0]       sr_in,
  input  logic [XLEN-1:0]       pc_next,
  input  logic [XLEN-1:0]       vbr,
  input  logic                  insn_boundary,
  output logic                  take,
  output logic [XLEN-1:0]       saved_pc,
  output logic [XLEN-1:0]       saved_sr,
  output logic [EVT_W-1:0]      evt_code,
  output logic [XLEN-1:0]       new_sr,
  output logic [XLEN-1:0]       target_pc
);
  localparam int IRQ_IW  = (N_IRQ  > 1) ? $clog2(N_IRQ)  : 1;
  localparam int PORT_IW = (N_PORT > 1) ? $clog2(N_PORT) : 1;
  localparam logic [XLEN-1:0] ENTRY_SET =
    (XLEN'(1) << BIT_BL) | (XLEN'(1) << BIT_RB) | (XLEN'(1) << BIT_MD);

  logic              sr_bl;
  logic [PRIO_W-1:0] sr_mask;
  logic              gate;
  logic              nmi_pend, nmi_go, lvl_go;
  logic              irq_hit, port_hit;
  logic [IRQ_IW-1:0] irq_idx;
  logic [PORT_IW-1:0] port_idx;
  logic              accept;
  src_e              src;
  logic [EVT_W-1:0]  code;

  assign sr_bl   = sr_in[BIT_BL];
  assign sr_mask = sr_in[IMASK_LO +: PRIO_W];
  // acceptance window: boundary, not blocked, not the cycle of a take
  assign gate    = insn_boundary & ~sr_bl & ~take;

  nmi_edge_latch u_nmi (
    .clk  (clk),
    .rst  (rst),
    .pin  (nmi_pin),
    .clr  (nmi_go),
    .pend (nmi_pend)
  );

  assign nmi_go = gate & nmi_pend;
  assign lvl_go = gate & (lvl_in != '0) & (lvl_in > sr_mask);

  prio_pick #(.N(N_IRQ), .PW(PRIO_W), .IDX_W(IRQ_IW)) u_irq (
    .req    (irq_pin),
    .prio   (irq_prio),
    .imask  (sr_mask),
    .enable (gate),
    .hit    (irq_hit),
    .idx    (irq_idx)
  );

  prio_pick #(.N(N_PORT), .PW(PRIO_W), .IDX_W(PORT_IW)) u_port (
    .req    (port_pin),
    .prio   (port_prio),
    .imask  (sr_mask),
    .enable (gate),
    .hit    (port_hit),
    .idx    (port_idx)
  );

  assign accept = nmi_go | lvl_go | irq_hit | port_hit;

  always_comb begin
    if (nmi_go)       src = SRC_NMI;
    else if (lvl_go)  src = SRC_LVL;
    else if (irq_hit) src = SRC_IRQ;
    else              src = SRC_PORT;
  end

  always_comb begin
    unique case (src)
      SRC_NMI:  code = EVT_NMI;
      SRC_LVL:  code = EVT_LVL_BASE  + EVT_W'(lvl_in)   * EVT_STEP;
      SRC_IRQ:  code = EVT_IRQ_BASE  + EVT_W'(irq_idx)  * EVT_STEP;
      default:  code = EVT_PORT_BASE + EVT_W'(port_idx) * EVT_STEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take      <= 1'b0;
      saved_pc  <= '0;
      saved_sr  <= '0;
      evt_code  <= '0;
      new_sr    <= '0;
      target_pc <= '0;
    end else begin
      take <= accept;
      if (accept) begin
        saved_pc  <= pc_next;
        saved_sr  <= sr_in;
        evt_code  <= code;
        new_sr    <= sr_in | ENTRY_SET;
        target_pc <= vbr + VEC_OFS;
      end
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
  import irq_accept_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_OFS = 'h600
) (
  input logic            clk,
  input logic            rst,
  input logic            insn_boundary,
  input logic [XLEN-1:0] sr_in,
  input logic [XLEN-1:0] pc_next,
  input logic [XLEN-1:0] vbr,
  input logic            take,
  input logic [XLEN-1:0] saved_pc,
  input logic [XLEN-1:0] saved_sr,
  input logic [XLEN-1:0] new_sr,
  input logic [XLEN-1:0] target_pc
);
  a_r8_needs_boundary: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(insn_boundary));

  a_r3_block_bit: assert property (@(posedge clk) disable iff (rst)
    take |-> !$past(sr_in[BIT_BL]));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);

  a_r9_saved_state: assert property (@(posedge clk) disable iff (rst)
    take |-> (saved_pc == $past(pc_next)) && (saved_sr == $past(sr_in)));

  a_r10_entry_sr: assert property (@(posedge clk) disable iff (rst)
    take |-> new_sr[BIT_BL] && new_sr[BIT_RB] && new_sr[BIT_MD] &&
             (new_sr[IMASK_LO +: PRIO_W] == saved_sr[IMASK_LO +: PRIO_W]));

  a_r11_target: assert property (@(posedge clk) disable iff (rst)
    take |-> target_pc == $past(vbr) + VEC_OFS);
endmodule

bind irq_accept_unit irq_accept_chk #(.XLEN(XLEN), .VEC_OFS(VEC_OFS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .insn_boundary (insn_boundary),
  .sr_in         (sr_in),
  .pc_next       (pc_next),
  .vbr           (vbr),
  .take          (take),
  .saved_pc      (saved_pc),
  .saved_sr      (saved_sr),
  .new_sr        (new_sr),
  .target_pc     (target_pc)
);

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;
  localparam int NI = 6;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_pin = 1'b0;
  logic [3:0] lvl_in = '0;
  logic [NI-1:0] irq_pin = '0;
  logic [NI*4-1:0] irq_prio = '0;
  logic [NP-1:0] port_pin = '0;
  logic [NP*4-1:0] port_prio = '0;
  logic [31:0] sr_in = '0, pc_next = '0, vbr = '0;
  logic insn_boundary = 1'b0;
  logic take;
  logic [31:0] saved_pc, saved_sr, new_sr, target_pc;
  logic [11:0] evt_code;

  always #2.5 clk = ~clk;

  irq_accept_unit #(.N_IRQ(NI), .N_PORT(NP)) u0 (
    .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .lvl_in(lvl_in),
    .irq_pin(irq_pin), .irq_prio(irq_prio), .port_pin(port_pin),
    .port_prio(port_prio), .sr_in(sr_in), .pc_next(pc_next), .vbr(vbr),
    .insn_boundary(insn_boundary), .take(take), .saved_pc(saved_pc),
    .saved_sr(saved_sr), .evt_code(evt_code), .new_sr(new_sr),
    .target_pc(target_pc));

  typedef struct {
    logic        tk;
    logic [11:0] code;
    logic [31:0] pc, sr, nsr, tgt;
    string       tag;
  } item_t;
  item_t sb[$];

  int checks = 0, errors = 0, cyc = 0;
  // stimulus variables for the next cycle
  logic b_nmi, b_bl, b_bnd;
  logic [3:0] b_lvl, b_mask;
  logic [NI-1:0] b_irq;
  logic [NI*4-1:0] b_ip;
  logic [NP-1:0] b_port;
  logic [NP*4-1:0] b_pp;
  // reference model state
  logic m_pend = 1'b0, m_prev = 1'b0, m_tkp = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    b_nmi = 0; b_bl = 0; b_bnd = 1; b_lvl = 0; b_mask = 0;
    b_irq = '0; b_ip = '0; b_port = '0; b_pp = '0;
  endtask

  task automatic step(input string tag);
    item_t it;
    logic g;
    logic [3:0] best;
    logic hit;
    @(negedge clk);
    cyc++;
    nmi_pin = b_nmi; lvl_in = b_lvl; irq_pin = b_irq; irq_prio = b_ip;
    port_pin = b_port; port_prio = b_pp; insn_boundary = b_bnd;
    sr_in = (32'(b_bl) << 28) | (32'(b_mask) << 4) | 32'h0000_0003 | (32'(cyc) << 12);
    pc_next = 32'h8000_0000 + 32'(cyc) * 2;
    vbr = 32'h0C00_0000 + 32'(cyc) * 32'h100;
    g = b_bnd && !m_tkp && !b_bl;
    it.tk = 0; it.code = 0; it.tag = tag;
    if (g && m_pend) begin it.tk = 1; it.code = 12'h1C0; end
    else if (g && b_lvl > b_mask) begin it.tk = 1; it.code = 12'h200 + 12'(b_lvl) * 12'h20; end
    else if (g) begin
      hit = 0; best = 0;
      for (int i = 0; i < NI; i++)
        if (b_irq[i] && b_ip[i*4 +: 4] > b_mask && (!hit || b_ip[i*4 +: 4] > best)) begin
          hit = 1; best = b_ip[i*4 +: 4]; it.code = 12'h600 + 12'(i) * 12'h20;
        end
      if (!hit)
        for (int j = 0; j < NP; j++)
          if (b_port[j] && b_pp[j*4 +: 4] > b_mask && (!hit || b_pp[j*4 +: 4] > best)) begin
            hit = 1; best = b_pp[j*4 +: 4]; it.code = 12'h700 + 12'(j) * 12'h20;
          end
      it.tk = hit;
    end
    it.pc = pc_next; it.sr = sr_in;
    it.nsr = (sr_in | 32'h7000_0000);
    it.tgt = vbr + 32'h600;
    m_pend = (m_pend && !(it.tk && it.code == 12'h1C0)) || (b_nmi && !m_prev);
    m_prev = b_nmi;
    m_tkp = it.tk;
    sb.push_back(it);
  endtask

  // monitor: compares one cycle after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        chk(take == e.tk, {e.tag, " take R12"}, 32'(take), 32'(e.tk));
        if (e.tk && take) begin
          chk(evt_code == e.code, {e.tag, " evt_code R7"}, 32'(evt_code), 32'(e.code));
          chk(saved_pc == e.pc && saved_sr == e.sr, {e.tag, " saved R9"}, saved_pc, e.pc);
          chk(new_sr == e.nsr, {e.tag, " new_sr R10"}, new_sr, e.nsr);
          chk(target_pc == e.tgt, {e.tag, " target R11"}, target_pc, e.tgt);
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #50000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    chk(take == 0, "R1 take after reset", 32'(take), 0);
    chk(saved_pc == 0 && saved_sr == 0 && new_sr == 0 && target_pc == 0 && evt_code == 0,
        "R1 record after reset", saved_pc, 0);

    idle(); b_lvl = 5; b_mask = 3; step("R4 level above mask");
    idle(); step("idle");
    idle(); b_lvl = 3; b_mask = 3; step("R4 level equal mask");
    idle(); b_lvl = 0; b_mask = 0; step("R13 level zero");
    idle(); b_lvl = 9; b_bnd = 0; step("R8 no boundary");
    idle(); b_lvl = 9; b_bl = 1; step("R3 block bit");
    idle(); b_irq[2] = 1; b_ip[8 +: 4] = 7; b_mask = 6; step("R5 irq2 accepted");
    idle(); step("idle");
    idle(); b_irq[2] = 1; b_ip[8 +: 4] = 7; b_mask = 7; step("R5 irq2 masked");
    idle(); b_irq[1] = 1; b_irq[4] = 1; b_ip[4 +: 4] = 9; b_ip[16 +: 4] = 9; step("R7 irq tie");
    idle(); step("idle");
    idle(); b_irq[1] = 1; b_irq[3] = 1; b_ip[4 +: 4] = 5; b_ip[12 +: 4] = 10; step("R7 irq higher prio");
    idle(); step("idle");
    idle(); b_port[5] = 1; b_pp[20 +: 4] = 4; step("R6 port5");
    idle(); step("idle");
    idle(); b_port[3] = 1; b_pp[12 +: 4] = 15; b_irq[0] = 1; b_ip[0 +: 4] = 2; step("R7 irq over port");
    idle(); step("idle");
    idle(); b_lvl = 2; b_irq[0] = 1; b_ip[0 +: 4] = 15; step("R7 level over irq");
    idle(); step("idle");
    idle(); b_nmi = 1; b_mask = 15; step("R2 nmi edge latched");
    idle(); b_nmi = 1; b_lvl = 9; step("R2 nmi over level");
    idle(); b_nmi = 1; b_lvl = 9; step("R12 gap after take");
    idle(); b_nmi = 1; step("R3 one take per edge");
    idle(); step("idle");
    idle(); b_nmi = 1; b_bl = 1; step("R3 nmi blocked a");
    idle(); b_nmi = 1; b_bl = 1; step("R3 nmi blocked b");
    idle(); b_nmi = 1; b_bl = 1; step("R3 nmi blocked c");
    idle(); b_nmi = 1; b_mask = 15; step("R3 nmi after block clears");
    idle(); step("idle");
    for (int k = 0; k < 3; k++) begin
      idle(); b_lvl = 8; step("R12 held level");
    end
    idle(); step("idle");
    idle(); step("idle");
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk); #2;
    summary();
  end
endmodule